// File: doc/BRIEF.md
# Loopback Channel Test Controller

This block runs a timed integrity test on a communications channel whose far end is looped back. After a go request it clears its counters and starts a session timer. It then drives an ascending count onto the transmit data output, one value per step. After a fixed number of settle cycles it compares the returned value with the value it sent. Each disagreement adds one to an error tally. When the session time has run out, the controller goes back to idle and raises a done flag. The final tally stays readable until the next run is started.

Sequencing comes from a seven-state Moore machine with fixed binary codes: idle 000, clear 001, settle 010, compare 011, error step 100, advance 101, time check 110. The session length is a number of seconds. A second is a parameterised count of clock cycles, so a short session can stand in for the full one.

Top module: `loopback_tester`

## Requirements
- R1: `tx_data` is 0 after a clear step and rises by exactly one in each advance step, wrapping modulo 2^DW; it changes at no other time.
- R2: While idle, `busy` is low and a high `go` sampled on a clock edge starts a run; `go` while `busy` is high has no effect on any output.
- R3: The cycle after `go` is accepted is the clear step. At the end of that cycle `tx_data` and `err_count` are 0 and the session timer restarts from zero.
- R4: Each value takes LAT settle cycles, one compare cycle, one error cycle only when the values differ, one advance cycle and one time check cycle, in that order. `busy` is high in all of them.
- R5: A compare cycle in which `rx_data` differs from `tx_data` raises `err_count` by exactly one at the end of the following error cycle. A matching compare leaves it unchanged.
- R6: `err_count` saturates at 2^EW-1 and never wraps to zero during a run.
- R7: The session expires once CYC_PER_SEC*SESSION_SECS cycles have elapsed after the clear step. The first time check cycle at or after expiry returns the controller to idle; any earlier one starts the next value.
- R8: `done` rises on the return to idle and stays high until the next `go` is accepted. While idle, `err_count` and `tx_data` hold their values.
- R9: After reset, the controller is idle with `busy` low, `done` low, `tx_data` 0 and `err_count` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start request, sampled only while idle |
| rx_data | input | DW | Value returned over the loopback path |
| tx_data | output | DW | Current test pattern value |
| err_count | output | EW | Mismatch tally, saturating |
| busy | output | 1 | High while a session runs |
| done | output | 1 | High after a session ends, until the next start |

## Verification
The bench targets four corner cases.
- It corrupts the returned data either for every value or for a periodic subset. A compare cycle sampled before the settle window ends, or an error step that fires on a match, then shows up as a tally off by some amount.
- It corrupts enough values to reach the tally ceiling. A design without saturation would wrap the tally to zero.
- It pulses go in the middle of a run. A design that restarts on that pulse would zero the pattern early.
- It checks the exact cycle of the return to idle against the expiry count. An off-by-one timer would stretch or cut the session by a whole value.

// File: rtl/loopback_tester.sv
module loopback_tester #(
  parameter int DW           = 16,
  parameter int EW           = 16,
  parameter int CYC_PER_SEC  = 200000000,
  parameter int SESSION_SECS = 30,
  parameter int LAT          = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] rx_data,
  output logic [DW-1:0] tx_data,
  output logic [EW-1:0] err_count,
  output logic          busy,
  output logic          done
);
  localparam int PW = (CYC_PER_SEC > 1) ? $clog2(CYC_PER_SEC) : 1;
  localparam int SW = (SESSION_SECS > 1) ? $clog2(SESSION_SECS) : 1;
  localparam int LW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [EW-1:0] EMAX = '1;

  localparam logic [2:0] S_IDLE = 3'b000;
  localparam logic [2:0] S_CLR  = 3'b001;
  localparam logic [2:0] S_WAIT = 3'b010;
  localparam logic [2:0] S_CMP  = 3'b011;
  localparam logic [2:0] S_ERR  = 3'b100;
  localparam logic [2:0] S_ADV  = 3'b101;
  localparam logic [2:0] S_CHK  = 3'b110;

  logic [2:0]    state;
  logic [LW-1:0] wcnt;
  logic [PW-1:0] pre;
  logic [SW-1:0] secs;
  logic          time_up;
  logic [DW-1:0] pat;
  logic [EW-1:0] errs;

  assign tx_data   = pat;
  assign err_count = errs;
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      wcnt  <= '0;
    end else begin
      case (state)
        S_IDLE: if (go) state <= S_CLR;
        S_CLR:  begin state <= S_WAIT; wcnt <= '0; end
        S_WAIT: begin
          if (wcnt == LW'(LAT - 1)) begin
            wcnt  <= '0;
            state <= S_CMP;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_CMP:  state <= (rx_data != pat) ? S_ERR : S_ADV;
        S_ERR:  state <= S_ADV;
        S_ADV:  state <= S_CHK;
        S_CHK:  state <= time_up ? S_IDLE : S_WAIT;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pat <= '0;
    else if (state == S_CLR)  pat <= '0;
    else if (state == S_ADV)  pat <= pat + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               errs <= '0;
    else if (state == S_CLR)                  errs <= '0;
    else if (state == S_ERR && errs != EMAX)  errs <= errs + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      secs    <= '0;
      time_up <= 1'b0;
    end else if (state == S_CLR) begin
      pre     <= '0;
      secs    <= '0;
      time_up <= 1'b0;
    end else if (state != S_IDLE && !time_up) begin
      if (pre == PW'(CYC_PER_SEC - 1)) begin
        pre <= '0;
        if (secs == SW'(SESSION_SECS - 1)) time_up <= 1'b1;
        else                              secs    <= secs + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          done <= 1'b0;
    else if (state == S_IDLE && go)      done <= 1'b0;
    else if (state == S_CHK && time_up)  done <= 1'b1;
  end
endmodule

// File: rtl/loopback_tester_chk.sv
module loopback_tester_chk #(
  parameter int DW = 16,
  parameter int EW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] tx_data,
  input logic [EW-1:0] err_count,
  input logic [2:0]    state
);
  localparam logic [EW-1:0] EMAX = '1;

  a_r1_pattern_moves_only_on_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 3'b101 && state != 3'b001) |=> $stable(tx_data));

  a_r2_go_starts_run: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go) |=> busy);

  a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'b001) |=> (tx_data == '0 && err_count == '0));

  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 3'b001) |=> (err_count == $past(err_count) ||
                           {1'b0, err_count} == {1'b0, $past(err_count)} + 1'b1));

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == EMAX && state != 3'b001) |=> (err_count == EMAX));

  a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> ($stable(err_count) && $stable(done) && !busy));
endmodule

bind loopback_tester loopback_tester_chk #(.DW(DW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done),
  .tx_data(tx_data), .err_count(err_count), .state(state)
);

// File: tb/tb_loopback_tester.sv
module tb_loopback_tester;
  localparam int DW = 8;
  localparam int EW = 3;
  localparam int CYC = 20;
  localparam int SECS = 5;
  localparam int LAT = 3;
  localparam int SPAN = CYC * SECS;

  logic clk = 0;
  logic rst_n = 0;
  logic go = 0;
  logic [DW-1:0] rx_data;
  logic [DW-1:0] tx_data;
  logic [EW-1:0] err_count;
  logic busy, done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int mode = 0;

  always #2.5 clk = ~clk;

  loopback_tester #(.DW(DW), .EW(EW), .CYC_PER_SEC(CYC), .SESSION_SECS(SECS), .LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .go(go), .rx_data(rx_data),
    .tx_data(tx_data), .err_count(err_count), .busy(busy), .done(done));

  function automatic bit bad(input int v);
    return (mode == 2) || (mode == 1 && (v % 4) == 2);
  endfunction

  logic [DW-1:0] pipe [LAT];
  always @(posedge clk) begin
    pipe[0] <= tx_data;
    for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
  end
  always_comb rx_data = pipe[LAT-1] ^ (bad(int'(pipe[LAT-1])) ? 8'h01 : 8'h00);

  // behavioural reference: phase names, elapsed-cycle count, integer tallies
  typedef enum int {P_IDLE, P_CLR, P_WAIT, P_CMP, P_ERR, P_ADV, P_CHK} phase_t;
  phase_t ph = P_IDLE;
  int m_pat = 0, m_err = 0, m_el = 0, m_w = 0;
  bit m_done = 0;
  int emax = (1 << EW) - 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = P_IDLE; m_pat = 0; m_err = 0; m_el = 0; m_w = 0; m_done = 0;
    end else begin
      case (ph)
        P_IDLE: if (go) begin ph = P_CLR; m_done = 0; end
        P_CLR:  begin m_pat = 0; m_err = 0; m_el = 0; m_w = 0; ph = P_WAIT; end
        P_WAIT: begin m_el++; if (m_w == LAT - 1) begin m_w = 0; ph = P_CMP; end else m_w++; end
        P_CMP:  begin m_el++; ph = bad(m_pat) ? P_ERR : P_ADV; end
        P_ERR:  begin m_el++; if (m_err < emax) m_err++; ph = P_ADV; end
        P_ADV:  begin m_el++; m_pat = (m_pat + 1) % (1 << DW); ph = P_CHK; end
        P_CHK:  begin
          if (m_el >= SPAN) begin ph = P_IDLE; m_done = 1; end
          else ph = P_WAIT;
          m_el++;
        end
        default: ph = P_IDLE;
      endcase
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    check("R1/R4 tx_data", int'(tx_data), m_pat);
    check("R5/R6 err_count", int'(err_count), m_err);
    check("R2/R7 busy", int'(busy), int'(ph != P_IDLE));
    check("R8 done", int'(done), int'(m_done));
  end

  task automatic run(input int md, input int poke);
    int n;
    @(negedge clk); mode = md; go = 1;
    @(negedge clk); go = 0;
    n = 0;
    while (!(done && !busy) && n < 2000) begin
      @(negedge clk); n++;
      if (n == poke) go = 1;
      else go = 0;
    end
    go = 0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 tx_data", int'(tx_data), 0);
    check("R9 err_count", int'(err_count), 0);
    check("R9 busy", int'(busy), 0);
    check("R9 done", int'(done), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    run(0, 0);
    check("R8 clean run done", int'(done), 1);
    check("R5 clean run tally", int'(err_count), 0);
    run(1, 40);   // R2: go pulse mid-run must be ignored
    check("R5 partial tally", int'(err_count), m_err);
    check("R8 done after partial", int'(done), 1);
    run(2, 0);
    check("R6 saturated tally", int'(err_count), emax);
    run(0, 0);
    check("R3 rerun clears tally", int'(err_count), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule